// File: doc/BRIEF.md
# Byte-Lane Write Data Memory

This block is a word-organised data store for a simple processor datapath. The core presents a 32-bit byte address, a 32-bit write value and a 2-bit access code. The block always returns the whole addressed 32-bit word on its read output. The access code picks one of four actions: leave the store untouched, or write one byte, one halfword or one full word.

A sub-word write changes only the byte lanes picked by the low address bits; the other bytes of that word keep their values. Inside, each byte lane is its own narrow array with its own write enable. The data for each lane is steered from the write value by the access code. The word index comes from the address bits just above the lane-select bits. Address bits above the configured depth are dropped, so higher addresses alias onto the same words.

Top module: `bytemem_top`

## Requirements
- R1: Access code 2'b00 is a read: no stored byte changes, and `rdata` shows the addressed word.
- R2: Access code 2'b01 writes `wdata[7:0]` into byte lane `addr[1:0]` of the addressed word. Lane k is bits [8k+7:8k], so lane 0 is the least significant byte.
- R3: Access code 2'b10 writes `wdata[15:0]`. It goes into bits [15:0] when `addr[1]`=0 and into bits [31:16] when `addr[1]`=1. `addr[0]` has no effect.
- R4: Access code 2'b11 writes all 32 bits of `wdata` into the addressed word. `addr[1:0]` has no effect.
- R5: On a byte or halfword write, every byte of the word outside the selected lanes keeps its previous value, and so does every other word.
- R6: A write takes effect at the rising clock edge. From the following cycle the read output shows the new word.
- R7: The word index is `addr[IDX_W+1:2]`, with IDX_W = log2(DEPTH). Higher address bits are ignored, so addresses that differ only there refer to the same word.
- R8: While `rst` is high, no access code changes any stored byte.
- R9: `rdata` follows `addr` combinationally within the same cycle, with no register stage.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes happen on its rising edge |
| rst | input | 1 | Synchronous active-high reset; blocks all writes while high |
| mem_ctl | input | 2 | Access code: 00 read, 01 byte write, 10 halfword write, 11 word write |
| addr | input | ADDR_W | Byte address; [1:0] select lanes, [IDX_W+1:2] select the word |
| wdata | input | DATA_W | Write value; the low byte or low halfword is used for sub-word writes |
| rdata | output | DATA_W | Whole addressed word, combinational |

## Verification
The hardest case to reach from the ports is a word whose bytes were last written by a mix of byte, halfword and word accesses. Only there does a lane-enable or steering fault show up as a wrong byte next to correct ones. The stimulus first fills every word with a distinct full-word pattern. It then walks all four byte lanes and both halves of chosen words, using set `addr[0]` bits and junk in the upper write bits. Finally it runs a long random mix of all four access codes with aliased upper address bits. A behavioural model compares every byte of the addressed word on every cycle.

// File: rtl/bytemem_pkg.sv
package bytemem_pkg;

  typedef enum logic [1:0] {
    MC_READ = 2'b00,
    MC_BYTE = 2'b01,
    MC_HALF = 2'b10,
    MC_WORD = 2'b11
  } memctl_e;

  localparam int unsigned LANE_W = 8;

endpackage

// File: rtl/bytemem_lane_dec.sv
// Turns the access code and lane-select bits into per-lane write enables,
// and steers the write value onto each lane without a barrel shifter.
module bytemem_lane_dec
  import bytemem_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  localparam int unsigned LANES  = DATA_W / LANE_W,
  localparam int unsigned LSEL_W = $clog2(LANES)
) (
  input  logic                clk,
  input  logic                rst,
  input  memctl_e             ctl,
  input  logic [LSEL_W-1:0]   lane_sel,
  input  logic [DATA_W-1:0]   wdata,
  output logic [LANES-1:0]    lane_we,
  output logic [DATA_W-1:0]   lane_data
);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    localparam logic [LSEL_W-1:0] LIDX = LSEL_W'(l);
    logic byte_hit;
    logic half_hit;

    assign byte_hit = (lane_sel == LIDX);
    assign half_hit = (lane_sel[LSEL_W-1:1] == LIDX[LSEL_W-1:1]);

    always_comb begin
      unique case (ctl)
        MC_BYTE: lane_we[l] = byte_hit;
        MC_HALF: lane_we[l] = half_hit;
        MC_WORD: lane_we[l] = 1'b1;
        default: lane_we[l] = 1'b0;
      endcase
    end

    always_comb begin
      unique case (ctl)
        MC_BYTE: lane_data[l*LANE_W +: LANE_W] = wdata[LANE_W-1:0];
        MC_HALF: lane_data[l*LANE_W +: LANE_W] = wdata[(l % 2)*LANE_W +: LANE_W];
        default: lane_data[l*LANE_W +: LANE_W] = wdata[l*LANE_W +: LANE_W];
      endcase
    end
  end

  // R1: a read drives no lane enable
  a_r1_read_no_lanes : assert property (@(posedge clk) disable iff (rst)
    (ctl == MC_READ) |-> (lane_we == '0));

  // R2: a byte write enables exactly the selected lane
  a_r2_byte_single_lane : assert property (@(posedge clk) disable iff (rst)
    (ctl == MC_BYTE) |-> ($countones(lane_we) == 1 && lane_we[lane_sel]));

  // R3: a halfword write enables two lanes of the selected half
  a_r3_half_pair : assert property (@(posedge clk) disable iff (rst)
    (ctl == MC_HALF) |-> ($countones(lane_we) == 2 && lane_we[lane_sel]));

  // R4: a word write enables every lane
  a_r4_word_all_lanes : assert property (@(posedge clk) disable iff (rst)
    (ctl == MC_WORD) |-> (&lane_we));

endmodule

// File: rtl/bytemem_lane_ram.sv
// One byte-wide storage lane: synchronous write, asynchronous read.
module bytemem_lane_ram #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned WIDTH = 8,
  localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] idx,
  input  logic [WIDTH-1:0] wbyte,
  output logic [WIDTH-1:0] rbyte
);

  logic [WIDTH-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      store[idx] <= wbyte;
    end
  end

  assign rbyte = store[idx];

endmodule

// File: rtl/bytemem_top.sv
module bytemem_top
  import bytemem_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DEPTH  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        mem_ctl,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);

  localparam int unsigned LANES  = DATA_W / LANE_W;
  localparam int unsigned LSEL_W = $clog2(LANES);
  localparam int unsigned IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  memctl_e             ctl;
  logic [IDX_W-1:0]    word_idx;
  logic [LSEL_W-1:0]   lane_sel;
  logic [LANES-1:0]    lane_we;
  logic [LANES-1:0]    lane_we_gated;
  logic [DATA_W-1:0]   lane_data;
  logic                unused_addr_hi;

  assign ctl      = memctl_e'(mem_ctl);
  assign lane_sel = addr[LSEL_W-1:0];
  assign word_idx = addr[LSEL_W +: IDX_W];
  assign unused_addr_hi = ^addr[ADDR_W-1:LSEL_W+IDX_W];

  bytemem_lane_dec #(
    .DATA_W (DATA_W)
  ) u_dec (
    .clk       (clk),
    .rst       (rst),
    .ctl       (ctl),
    .lane_sel  (lane_sel),
    .wdata     (wdata),
    .lane_we   (lane_we),
    .lane_data (lane_data)
  );

  // R8: reset holds every lane closed
  assign lane_we_gated = rst ? '0 : lane_we;

  for (genvar l = 0; l < LANES; l++) begin : g_ram
    bytemem_lane_ram #(
      .DEPTH (DEPTH),
      .WIDTH (LANE_W)
    ) u_ram (
      .clk   (clk),
      .we    (lane_we_gated[l]),
      .idx   (word_idx),
      .wbyte (lane_data[l*LANE_W +: LANE_W]),
      .rbyte (rdata[l*LANE_W +: LANE_W])
    );
  end

  // R1: a read at an unchanged address leaves the returned word unchanged
  a_r1_read_keeps_word : assert property (@(posedge clk) disable iff (rst)
    (ctl == MC_READ) |=> (!$stable(addr) || $stable(rdata)));

  // R4/R6: a full-word write is seen whole on the next cycle at that address
  a_r6_word_visible : assert property (@(posedge clk) disable iff (rst)
    (!rst && ctl == MC_WORD) |=> (!$stable(addr) || rdata == $past(wdata)));

  // R2/R5: a byte write at lane 0 leaves the three upper bytes unchanged
  a_r5_byte0_keeps_upper : assert property (@(posedge clk) disable iff (rst)
    (!rst && ctl == MC_BYTE && lane_sel == '0) |=>
      (!$stable(addr) ||
       (rdata[DATA_W-1:LANE_W] == $past(rdata[DATA_W-1:LANE_W]) &&
        rdata[LANE_W-1:0] == $past(wdata[LANE_W-1:0]))));

endmodule

// File: tb/bytemem_top_test.sv
module bytemem_top_test;

  localparam int unsigned PERIOD = 10;
  localparam int unsigned DEPTH  = 16;
  localparam int unsigned IDX_W  = $clog2(DEPTH);

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  mem_ctl = 2'b00;
  logic [31:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;

  int compared   = 0;
  int mismatched = 0;

  logic [31:0] model [DEPTH];
  bit          known [DEPTH];

  always #(PERIOD/2) clk = ~clk;

  bytemem_top #(.ADDR_W(32), .DATA_W(32), .DEPTH(DEPTH)) uut (
    .clk     (clk),
    .rst     (rst),
    .mem_ctl (mem_ctl),
    .addr    (addr),
    .wdata   (wdata),
    .rdata   (rdata)
  );

  function automatic int widx(input logic [31:0] a);
    return int'(a[IDX_W+1:2]);
  endfunction

  task automatic check_now(input string tag);
    int i;
    i = widx(addr);
    if (known[i]) begin
      compared++;
      if (rdata !== model[i]) begin
        mismatched++;
        $display("FAIL %s addr=%h actual=%h expected=%h", tag, addr, rdata, model[i]);
      end
    end
  endtask

  task automatic apply_model(input logic [1:0] c, input logic [31:0] a, input logic [31:0] d);
    int i;
    i = widx(a);
    case (c)
      2'b01: model[i][8*a[1:0] +: 8] = d[7:0];
      2'b10: model[i][16*a[1] +: 16] = d[15:0];
      2'b11: begin model[i] = d; known[i] = 1'b1; end
      default: ;
    endcase
  endtask

  task automatic step(input logic r, input logic [1:0] c, input logic [31:0] a,
                      input logic [31:0] d, input string tag);
    @(negedge clk);
    rst = r; mem_ctl = c; addr = a; wdata = d;
    #1;
    check_now(tag);
    @(posedge clk);
    if (!r) apply_model(c, a, d);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    #(PERIOD * 200000);
    mismatched++;
    $display("FAIL watchdog (R6) actual=running expected=finished");
    finish_run();
  end

  initial begin
    // reset cycles with write attempts; nothing is known yet
    for (int k = 0; k < 3; k++) step(1'b1, 2'b11, 32'(k*4), 32'hBAD0_0000 + k, "R8");

    // R4: fill every word, low address bits deliberately nonzero
    for (int k = 0; k < DEPTH; k++)
      step(1'b0, 2'b11, 32'(k*4 + (k % 4)), 32'hA5000000 ^ (32'(k) * 32'h01030507), "R4");

    // R1/R6: read every word back
    for (int k = 0; k < DEPTH; k++) step(1'b0, 2'b00, 32'(k*4), 32'hFFFF_FFFF, "R1");
    step(1'b0, 2'b00, 32'h8, 32'h0, "R1");

    // R8: write during reset must not land
    step(1'b1, 2'b11, 32'h14, 32'hDEAD_BEEF, "R8");
    step(1'b1, 2'b01, 32'h15, 32'hFFFF_FF77, "R8");
    step(1'b0, 2'b00, 32'h14, 32'h0, "R8");

    // R2/R5: each lane of word 3, junk in the upper write bits
    for (int l = 0; l < 4; l++) begin
      step(1'b0, 2'b01, 32'h0C + 32'(l), 32'hEEEEEE00 | 32'(8'h10 + l), "R2");
      step(1'b0, 2'b00, 32'h0C, 32'h0, "R5");
    end

    // R3: halves of word 7, addr[0] set
    step(1'b0, 2'b10, 32'h1D, 32'hCCCC_1234, "R3");
    step(1'b0, 2'b00, 32'h1C, 32'h0, "R3");
    step(1'b0, 2'b10, 32'h1F, 32'hCCCC_ABCD, "R3");
    step(1'b0, 2'b00, 32'h1C, 32'h0, "R3");
    step(1'b0, 2'b00, 32'h18, 32'h0, "R5");

    // R7: aliased upper address bits
    step(1'b0, 2'b11, 32'hFFFF_FF24, 32'h0F1E_2D3C, "R7");
    step(1'b0, 2'b00, 32'h0000_0024, 32'h0, "R7");
    step(1'b0, 2'b01, 32'h1230_0026, 32'h0000_0099, "R7");
    step(1'b0, 2'b00, 32'h8000_0024, 32'h0, "R7");

    // R9: address change inside one cycle
    @(negedge clk);
    mem_ctl = 2'b00; addr = 32'h0C; #1; check_now("R9");
    addr = 32'h1C; #1; check_now("R9");
    addr = 32'h24; #1; check_now("R9");

    // R5/R6: long random mix
    for (int k = 0; k < 600; k++)
      step(1'b0, 2'($urandom_range(0, 3)), $urandom, $urandom, "R5");
    step(1'b0, 2'b00, 32'h0, 32'h0, "R6");

    finish_run();
  end

endmodule